// File: doc/BRIEF.md
# Generate/Capture Timer Channel

A single timer channel built around a counter, a load register and a control word. In generate mode the counter starts from the load value and counts up or down. When it wraps it raises a one-clock output pulse and an event flag. It then either reloads and keeps going, or stops where it wrapped. In capture mode the counter runs freely, and a synchronized edge on an external trigger copies the running count into the load register.

Software reaches the channel through a small register port. This port has one shared word address, write data, a write strobe and a read strobe, and read data is combinational on the address. A freeze input stalls counting and events for debug. A start-all strobe lets several channels be started in the same cycle.

The event flag is sticky and can only be cleared by writing a one to it. The interrupt line is the flag gated by an interrupt-enable bit.

Top module: `timer_channel`

## Requirements
- R1: After reset the control word, load register and count read 0, the pulse output is inactive and the interrupt is low. Word addresses are 0 (control), 1 (load) and 2 (count). Control bits 9 and 11 and everything above bit 10 read 0, whatever is written to them.
- R2: While the force-load bit (bit 5) is 1, the count equals the load register and does not move. With run (bit 7) set and force-load clear, the count changes by one every clock.
- R3: In generate mode (bit 0 = 0) counting down (bit 1 = 1) with auto-reload (bit 4 = 1), pulses are exactly load+2 clocks apart. Each pulse lasts one clock while the pulse-enable bit (bit 2) is 1.
- R4: In generate mode counting up (bit 1 = 0) with auto-reload, pulses are exactly MAX-load+2 clocks apart, where MAX is the all-ones count.
- R5: With auto-reload clear, a generate wrap yields one pulse and the count then stays at its wrapped value (all-ones when counting down).
- R6: With the pulse-enable bit clear, wraps still set the event flag (bit 8) but no pulse appears.
- R7: Writing 1 to the flag bit clears it. Writing 0 to it leaves it set.
- R8: The interrupt output is high exactly when the flag and the interrupt-enable bit (bit 6) are both 1. Clearing interrupt-enable does not clear the flag.
- R9: In capture mode (bit 0 = 1, trigger enable bit 3 = 1, run = 1), the trigger is sampled through SYNC_STAGES flops. Only its move into the asserted level captures: the stored value is the count SYNC_STAGES clocks after the trigger changed, and the flag is set. Holding the level or releasing it captures nothing.
- R10: With auto-reload clear in capture mode, a captured value is kept until the load register is read. Triggers before that read are dropped.
- R11: With auto-reload set in capture mode, every capture overwrites the load register.
- R12: With run clear, a trigger edge neither sets the flag nor changes the load register.
- R13: Writing the control word with bit 10 set sets both bit 10 and run. With bit 10 clear, bit 10 clears and run takes the written run bit. A one-clock pulse on start_all sets both.
- R14: While freeze is high the count holds and no pulse occurs. Register writes and reads still work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (marks a load-register read) |
| rd_data | output | DATA_W | Combinational read data for addr |
| trig_in | input | 1 | External capture trigger |
| freeze | input | 1 | Debug halt of counting and events |
| start_all | input | 1 | One-clock strobe that sets run and all-enable |
| gen_out | output | 1 | One-clock wrap pulse, polarity GEN_POL |
| irq | output | 1 | Flag AND interrupt-enable |

## Verification
Wrap intervals are measured with random load values and directions. This tells the down formula from the up formula, and a reload taken one cycle early or late shows up as a period that is off by one. The directed corners are the shortest period (load 0 down, load MAX up), hold mode against reload mode, and a pulse-disabled wrap that must still set the flag. Capture is exercised with short pulses, a long held level, back-to-back triggers with and without a read in between, and a trigger while stopped. This separates edge from level detection, overwrite from keep, and gating by run.

// File: rtl/tmr_pkg.sv
// Shared control-word layout and register addresses for the timer channel.
package tmr_pkg;
    // control word bit positions
    localparam int BIT_MODE = 0;   // 0 generate, 1 capture
    localparam int BIT_DOWN = 1;   // count direction
    localparam int BIT_GEN  = 2;   // pulse output enable
    localparam int BIT_TRIG = 3;   // capture trigger enable
    localparam int BIT_AUTO = 4;   // reload / overwrite
    localparam int BIT_LOAD = 5;   // force count from load register
    localparam int BIT_IEN  = 6;   // interrupt enable
    localparam int BIT_RUN  = 7;   // run
    localparam int BIT_FLAG = 8;   // sticky event flag
    localparam int BIT_ALL  = 10;  // all-enable mirror

    // word addresses
    localparam int REG_CTRL  = 0;
    localparam int REG_LOAD  = 1;
    localparam int REG_COUNT = 2;

    typedef struct packed {
        logic all_en;
        logic flag;
        logic run;
        logic ien;
        logic force_ld;
        logic auto_rl;
        logic trig_en;
        logic gen_en;
        logic down;
        logic capt;
    } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
// Control word storage.
// Assumes wr_ctrl is already decoded from the address.
// The flag is set by events and cleared only by a written one; a set in the same cycle wins.
module tmr_ctrl_reg
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_all,
    input  logic              flag_set,
    output ctrl_t             ctrl
);
    logic unused_bits;
    assign unused_bits = ^wdata;

    // update control fields from writes, the start strobe and events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.capt     <= wdata[BIT_MODE];
                ctrl.down     <= wdata[BIT_DOWN];
                ctrl.gen_en   <= wdata[BIT_GEN];
                ctrl.trig_en  <= wdata[BIT_TRIG];
                ctrl.auto_rl  <= wdata[BIT_AUTO];
                ctrl.force_ld <= wdata[BIT_LOAD];
                ctrl.ien      <= wdata[BIT_IEN];
                ctrl.run      <= wdata[BIT_RUN] | wdata[BIT_ALL];
                ctrl.all_en   <= wdata[BIT_ALL];
                if (wdata[BIT_FLAG]) begin
                    ctrl.flag <= 1'b0;
                end
            end
            if (start_all) begin
                ctrl.all_en <= 1'b1;
                ctrl.run    <= 1'b1;
            end
            if (flag_set) begin
                ctrl.flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Up/down counter with force-load, wrap detection and delayed reload.
// A generate-mode wrap lets the counter step through the wrapped value for one cycle.
// That extra state makes the interval load+2 (down) or MAX-load+2 (up).
// It then reloads, or halts until the next force-load.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic             force_ld,
    input  logic             run,
    input  logic             down,
    input  logic             gen_mode,
    input  logic             auto_rl,
    input  logic             freeze,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic             pend_q;
    logic             halt_q;
    logic             step;
    logic [CNT_W-1:0] term;

    assign step     = run & ~force_ld & ~halt_q & ~freeze & ~pend_q;
    assign term     = down ? '0 : ALL_ONES;
    assign wrap_evt = step & gen_mode & (cnt == term);

    // count value: force-load, pending reload, or one step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (force_ld) begin
            cnt <= load_val;
        end else if (pend_q && !freeze && auto_rl) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
        end
    end

    // wrap follow-up state: pending reload and hold-mode halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            halt_q <= 1'b0;
        end else if (force_ld) begin
            pend_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (wrap_evt) begin
                pend_q <= 1'b1;
            end else if (!freeze) begin
                pend_q <= 1'b0;
            end
            if (pend_q && !freeze && !auto_rl) begin
                halt_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_capture.sv
// Trigger synchronizer, edge detector and capture gating.
// Assumes trig_in may be asynchronous to clk.
// The edge is the move of the synchronized level into TRIG_POL.
// Without auto-overwrite, a held capture blocks new ones until it is read.
module tmr_capture #(
    parameter int   SYNC_STAGES = 2,
    parameter logic TRIG_POL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic arm,
    input  logic auto_rl,
    input  logic rd_load,
    output logic cap_evt,
    output logic cap_wr
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   prev_q;
    logic                   unread_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        // one synchronizer stage, reset to the idle level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[g] <= ~TRIG_POL;
            end else if (g == 0) begin
                sync_q[g] <= trig_in;
            end else begin
                sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign lvl     = (sync_q[SYNC_STAGES-1] == TRIG_POL);
    assign cap_evt = lvl & ~prev_q & arm;
    assign cap_wr  = cap_evt & (auto_rl | ~unread_q);

    // previous asserted level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // unread marker for the held capture value
    always_ff @(posedge clk) begin
        if (!rst_n)       unread_q <= 1'b0;
        else if (cap_wr)  unread_q <= 1'b1;
        else if (rd_load) unread_q <= 1'b0;
    end
endmodule

// File: rtl/timer_channel.sv
// Top of the timer channel.
// Decodes the register port and holds the load register.
// Joins the control word, the counter and the capture logic, and registers the pulse output.
// Assumes CNT_W <= DATA_W and addr is a word address.
module timer_channel
    import tmr_pkg::*;
#(
    parameter int   ADDR_W      = 2,
    parameter int   DATA_W      = 32,
    parameter int   CNT_W       = 32,
    parameter int   SYNC_STAGES = 2,
    parameter logic TRIG_POL    = 1'b1,
    parameter logic GEN_POL     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              trig_in,
    input  logic              freeze,
    input  logic              start_all,
    output logic              gen_out,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] AD_LOAD  = ADDR_W'(REG_LOAD);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(REG_COUNT);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap_evt;
    logic              cap_evt;
    logic              cap_wr;
    logic              gen_q;
    logic              wr_ctrl;
    logic              wr_load;
    logic              rd_load;
    logic              arm;
    logic [DATA_W-1:0] ctrl_word;

    assign wr_ctrl = wr_en & (addr == AD_CTRL);
    assign wr_load = wr_en & (addr == AD_LOAD);
    assign rd_load = rd_en & (addr == AD_LOAD);
    assign arm     = ctrl_q.run & ctrl_q.capt & ctrl_q.trig_en & ~freeze;

    tmr_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .start_all (start_all),
        .flag_set  (wrap_evt | cap_evt),
        .ctrl      (ctrl_q)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (load_q),
        .force_ld (ctrl_q.force_ld),
        .run      (ctrl_q.run),
        .down     (ctrl_q.down),
        .gen_mode (~ctrl_q.capt),
        .auto_rl  (ctrl_q.auto_rl),
        .freeze   (freeze),
        .cnt      (cnt_q),
        .wrap_evt (wrap_evt)
    );

    tmr_capture #(.SYNC_STAGES(SYNC_STAGES), .TRIG_POL(TRIG_POL)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .arm     (arm),
        .auto_rl (ctrl_q.auto_rl),
        .rd_load (rd_load),
        .cap_evt (cap_evt),
        .cap_wr  (cap_wr)
    );

    // load register: capture has priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (cap_wr)  load_q <= cnt_q;
        else if (wr_load) load_q <= wdata[CNT_W-1:0];
    end

    // one-cycle pulse after a generate wrap
    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= 1'b0;
        else        gen_q <= wrap_evt & ctrl_q.gen_en;
    end

    // pack the control fields into their bit positions
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_MODE] = ctrl_q.capt;
        ctrl_word[BIT_DOWN] = ctrl_q.down;
        ctrl_word[BIT_GEN]  = ctrl_q.gen_en;
        ctrl_word[BIT_TRIG] = ctrl_q.trig_en;
        ctrl_word[BIT_AUTO] = ctrl_q.auto_rl;
        ctrl_word[BIT_LOAD] = ctrl_q.force_ld;
        ctrl_word[BIT_IEN]  = ctrl_q.ien;
        ctrl_word[BIT_RUN]  = ctrl_q.run;
        ctrl_word[BIT_FLAG] = ctrl_q.flag;
        ctrl_word[BIT_ALL]  = ctrl_q.all_en;
    end

    // read data selection
    always_comb begin
        case (addr)
            AD_CTRL:  rd_data = ctrl_word;
            AD_LOAD:  rd_data = DATA_W'(load_q);
            AD_COUNT: rd_data = DATA_W'(cnt_q);
            default:  rd_data = '0;
        endcase
    end

    assign gen_out = gen_q ? GEN_POL : ~GEN_POL;
    assign irq     = ctrl_q.flag & ctrl_q.ien;
endmodule

// File: rtl/timer_channel_chk.sv
// Property checker bound to timer_channel; observes ports and internal state only.
module timer_channel_chk
    import tmr_pkg::*;
#(
    parameter int   ADDR_W  = 2,
    parameter int   DATA_W  = 32,
    parameter int   CNT_W   = 32,
    parameter logic GEN_POL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              freeze,
    input logic              gen_out,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_q,
    input ctrl_t             ctrl
);
    logic gen_act;
    assign gen_act = (gen_out == GEN_POL);

    // R3: the wrap pulse never lasts two clocks
    p_gen_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gen_act |=> !gen_act);

    // R2: force-load puts the load value into the counter
    p_load_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.force_ld |=> (cnt == $past(load_q)));

    // R14: freeze without force-load keeps the count
    p_freeze_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !ctrl.force_ld) |=> $stable(cnt));

    // R7: the flag only falls after a written one
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flag && !(wr_en && addr == ADDR_W'(REG_CTRL) && wdata[BIT_FLAG])) |=> ctrl.flag);

    // R12: a pulse needs a running, unfrozen counter in the cycle before
    p_gen_needs_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        gen_act |-> ($past(ctrl.run) && !$past(freeze)));

    // R8: interrupt only with the flag raised
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl.flag);

    // R1: unused control bits read zero
    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(REG_CTRL)) |-> (rd_data[DATA_W-1:11] == '0 && rd_data[9] == 1'b0));
endmodule

bind timer_channel timer_channel_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .GEN_POL(GEN_POL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .freeze  (freeze),
    .gen_out (gen_out),
    .irq     (irq),
    .cnt     (cnt_q),
    .load_q  (load_q),
    .ctrl    (ctrl_q)
);

// File: tb/timer_channel_tb.sv
`timescale 1ns/1ps
module timer_channel_tb;
    import tmr_pkg::*;

    localparam int DW = 32;
    localparam int CW = 32;
    localparam int SY = 2;
    localparam logic [CW-1:0] MAXV = '1;
    localparam logic [DW-1:0] C_CAPT = DW'(1) << BIT_MODE;
    localparam logic [DW-1:0] C_DOWN = DW'(1) << BIT_DOWN;
    localparam logic [DW-1:0] C_GEN  = DW'(1) << BIT_GEN;
    localparam logic [DW-1:0] C_TRIG = DW'(1) << BIT_TRIG;
    localparam logic [DW-1:0] C_AUTO = DW'(1) << BIT_AUTO;
    localparam logic [DW-1:0] C_LOAD = DW'(1) << BIT_LOAD;
    localparam logic [DW-1:0] C_IEN  = DW'(1) << BIT_IEN;
    localparam logic [DW-1:0] C_RUN  = DW'(1) << BIT_RUN;
    localparam logic [DW-1:0] C_FLAG = DW'(1) << BIT_FLAG;
    localparam logic [DW-1:0] C_ALL  = DW'(1) << BIT_ALL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          trig_in = 1'b0;
    logic          freeze = 1'b0;
    logic          start_all = 1'b0;
    logic          gen_out;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    timer_channel u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .trig_in(trig_in), .freeze(freeze),
        .start_all(start_all), .gen_out(gen_out), .irq(irq)
    );

    function automatic longint exp_period(bit dn, logic [CW-1:0] ld);
        if (dn) return longint'(ld) + 2;
        return longint'(MAXV - ld) + 2;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        addr = 2'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [DW-1:0] q);
        @(negedge clk);
        addr = 2'(a); rd_en = 1'b1;
        #1 q = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(int a, output logic [DW-1:0] q);
        @(negedge clk);
        addr = 2'(a);
        #1 q = rd_data;
    endtask

    task automatic wait_pulse(int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (gen_out !== 1'b1 && n < limit);
    endtask

    task automatic count_pulses(int cycles, output int p);
        p = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (gen_out === 1'b1) p++;
        end
    endtask

    // assert the trigger for hold cycles; c0 is the count at the change
    task automatic trig_pulse(int hold, output logic [DW-1:0] c0);
        @(negedge clk);
        addr = 2'(REG_COUNT); trig_in = 1'b1;
        #1 c0 = rd_data;
        repeat (hold) @(negedge clk);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_period(bit dn, logic [CW-1:0] ld);
        logic [DW-1:0] base;
        logic [DW-1:0] q;
        int n;
        base = C_GEN | C_AUTO | (dn ? C_DOWN : '0);
        wr(REG_LOAD, DW'(ld));
        wr(REG_CTRL, base | C_LOAD);
        wr(REG_CTRL, base | C_RUN | C_FLAG);
        wait_pulse(1000, n);
        wait_pulse(1000, n);
        check(dn ? "R3 down interval" : "R4 up interval", n, exp_period(dn, ld));
        @(negedge clk);
        check("R3 pulse width", gen_out, 0);
        peek(REG_CTRL, q);
        check("R3 flag after wrap", q[BIT_FLAG], 1);
        wr(REG_CTRL, C_FLAG);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [DW-1:0] q, c0, c1, c2;
        int n, p;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and unused bits
        peek(REG_CTRL, q);  check("R1 ctrl", q, 0);
        peek(REG_LOAD, q);  check("R1 load", q, 0);
        peek(REG_COUNT, q); check("R1 count", q, 0);
        check("R1 gen_out", gen_out, 0);
        check("R1 irq", irq, 0);
        wr(REG_CTRL, 32'hFFFF_FA00);
        peek(REG_CTRL, q);  check("R1 reserved bits", q, 0);

        // R2 force-load holds, then running steps
        wr(REG_LOAD, 32'h1234);
        wr(REG_CTRL, C_LOAD | C_RUN | C_DOWN);
        peek(REG_COUNT, q); check("R2 forced", q, 32'h1234);
        repeat (3) @(negedge clk);
        peek(REG_COUNT, q); check("R2 held", q, 32'h1234);
        wr(REG_CTRL, C_RUN | C_DOWN);
        repeat (3) @(negedge clk);
        peek(REG_COUNT, q); check("R2 running", q, 32'h1230);
        wr(REG_CTRL, C_FLAG);

        // R3/R4 directed shortest periods, then random
        run_period(1'b1, '0);
        run_period(1'b0, MAXV);
        for (int i = 0; i < 8; i++) begin
            bit dn;
            int k;
            dn = 1'($urandom_range(0, 1));
            k = int'($urandom_range(0, 12));
            run_period(dn, dn ? CW'(k) : MAXV - CW'(k));
        end

        // R5 hold after a single wrap
        wr(REG_LOAD, 2);
        wr(REG_CTRL, C_GEN | C_DOWN | C_LOAD);
        wr(REG_CTRL, C_GEN | C_DOWN | C_RUN);
        count_pulses(40, p);
        check("R5 single pulse", p, 1);
        peek(REG_COUNT, q); check("R5 held value", q, DW'(MAXV));
        wr(REG_CTRL, C_FLAG);

        // R6 pulse disabled still flags
        wr(REG_LOAD, 3);
        wr(REG_CTRL, C_AUTO | C_DOWN | C_LOAD);
        wr(REG_CTRL, C_AUTO | C_DOWN | C_RUN);
        count_pulses(40, p);
        check("R6 no pulse", p, 0);
        peek(REG_CTRL, q); check("R6 flag set", q[BIT_FLAG], 1);

        // R8 interrupt gating
        check("R8 irq off with ien=0", irq, 0);
        wr(REG_CTRL, C_AUTO | C_DOWN | C_RUN | C_IEN);
        @(negedge clk);
        check("R8 irq on", irq, 1);
        wr(REG_CTRL, 0);
        @(negedge clk);
        check("R8 irq off after ien clear", irq, 0);
        peek(REG_CTRL, q); check("R8 flag kept", q[BIT_FLAG], 1);

        // R7 write-0 keeps, write-1 clears
        wr(REG_CTRL, 0);
        peek(REG_CTRL, q); check("R7 write 0 keeps", q[BIT_FLAG], 1);
        wr(REG_CTRL, C_FLAG);
        peek(REG_CTRL, q); check("R7 write 1 clears", q[BIT_FLAG], 0);

        // R13 all-enable behaviour
        wr(REG_CTRL, C_ALL);
        peek(REG_CTRL, q); check("R13 all sets run", q & (C_ALL | C_RUN), C_ALL | C_RUN);
        wr(REG_CTRL, C_RUN);
        peek(REG_CTRL, q); check("R13 all cleared", q & (C_ALL | C_RUN), C_RUN);
        wr(REG_CTRL, 0);
        @(negedge clk); start_all = 1'b1;
        @(negedge clk); start_all = 1'b0;
        peek(REG_CTRL, q); check("R13 strobe", q & (C_ALL | C_RUN), C_ALL | C_RUN);
        wr(REG_CTRL, C_FLAG);

        // R14 freeze
        wr(REG_LOAD, 100);
        wr(REG_CTRL, C_GEN | C_AUTO | C_DOWN | C_LOAD);
        wr(REG_CTRL, C_GEN | C_AUTO | C_DOWN | C_RUN);
        @(negedge clk); freeze = 1'b1;
        repeat (2) @(negedge clk);
        peek(REG_COUNT, c1);
        count_pulses(300, p);
        check("R14 no pulse frozen", p, 0);
        peek(REG_COUNT, c2); check("R14 count held", c2, c1);
        wr(REG_LOAD, 32'h55);
        rd(REG_LOAD, q); check("R14 access while frozen", q, 32'h55);
        freeze = 1'b0;
        repeat (3) @(negedge clk);
        peek(REG_COUNT, c2); check("R14 resumes", (c2 != c1), 1);
        wr(REG_CTRL, C_FLAG);

        // R9/R11 capture with overwrite
        wr(REG_LOAD, 0);
        wr(REG_CTRL, C_CAPT | C_TRIG | C_AUTO | C_LOAD);
        wr(REG_CTRL, C_CAPT | C_TRIG | C_AUTO | C_RUN);
        trig_pulse(4, c0);
        rd(REG_LOAD, q); check("R9 captured value", q, c0 + SY);
        peek(REG_CTRL, q); check("R9 flag on capture", q[BIT_FLAG], 1);
        trig_pulse(4, c1);
        rd(REG_LOAD, q); check("R11 overwrite", q, c1 + SY);
        trig_pulse(30, c2);
        rd(REG_LOAD, q); check("R9 level and release ignored", q, c2 + SY);

        // R10 keep until read
        wr(REG_CTRL, C_CAPT | C_TRIG | C_RUN);
        trig_pulse(4, c0);
        trig_pulse(4, c1);
        rd(REG_LOAD, q); check("R10 second capture dropped", q, c0 + SY);
        trig_pulse(4, c2);
        rd(REG_LOAD, q); check("R10 capture after read", q, c2 + SY);

        // R12 stopped timer ignores triggers
        wr(REG_CTRL, C_CAPT | C_TRIG | C_FLAG);
        rd(REG_LOAD, c1);
        trig_pulse(4, c0);
        peek(REG_LOAD, q); check("R12 load unchanged", q, c1);
        peek(REG_CTRL, q); check("R12 no flag", q[BIT_FLAG], 0);

        report();
    end
endmodule